// File: doc/BRIEF.md
# 32 kHz Timestamp Counter with Coherent Halfword Reads

This block is a read-only timestamp source on a simple register bus. A free-running 32-bit counter advances by one on each 32768 Hz tick. The tick arrives as a one-cycle enable pulse that is synchronous to the bus clock. The counter starts at zero when reset is released, so the count is the number of ticks since reset. On the bus, software sees a fixed identification register and the live count. There is no configuration and there are no interrupts.

Some masters can only make 16-bit accesses. For them, a 16-bit read of the lower half of a register also stores that register's upper half in a holding register. A later 16-bit read with address bit 1 set returns the stored half and does not take a new sample. The two halves therefore come from the same instant.

Every access completes without wait states. The read data and a one-cycle error flag appear on the cycle after the strobe. Writes, byte-wide reads and reads of unmapped offsets are refused. The counter wraps from all ones to zero and gives no indication of the wrap.

Top module: `stamp32k_timer`

## Requirements
- R1: The count rises by exactly one on each clock edge that samples `tick_en` high. It is unchanged on every other edge and wraps from 0xFFFFFFFF to 0.
- R2: After reset the count is zero, the holding register is zero, `rdata` is zero and `err` is low.
- R3: A 32-bit read (`bus_size` = 2) at offset 0x00 returns 0x00000021, with `err` low.
- R4: A 32-bit read at offset 0x10 returns the count as it stood in the strobe cycle. `rdata` and `err` are registered, so they show the result on the cycle after the strobe.
- R5: A 16-bit read (`bus_size` = 1) with address bit 1 clear returns, zero-extended, the low 16 bits of what a 32-bit read of the same address would return. It loads the upper 16 bits into the holding register: the count's upper half at 0x10, zero at 0x00, and zero at an unmapped offset.
- R6: A 16-bit read with address bit 1 set returns the holding register, zero-extended, at any offset. It raises no error and changes no state.
- R7: A write of any size to any offset raises `err` and changes neither the count's course nor the holding register. A strobe with both `bus_rd` and `bus_wr` high counts as a write.
- R8: A read with `bus_size` 0 (byte) or 3 (reserved) raises `err`, returns zero and leaves the holding register unchanged.
- R9: A 32-bit read, or a 16-bit read with bit 1 clear, at any offset other than 0x00 or 0x10 raises `err` and returns zero.
- R10: `err` is high for exactly the one cycle that follows a refused strobe. On a cycle after no strobe, `rdata` is zero and `err` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | One-cycle 32768 Hz tick, synchronous to `clk` |
| bus_addr | input | ADDR_W (8) | Byte offset within the block |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_size | input | 2 | Access size: 0 byte, 1 halfword, 2 word, 3 reserved |
| rdata | output | DATA_W (32) | Read data, valid the cycle after the strobe |
| err | output | 1 | One-cycle pulse for a refused access |

## Verification
Only one piece of internal state can be wrong and still stay hidden: the holding register. A missed load or a stray load only shows up at the next high-half read. The bench therefore places upper-half reads after writes, byte reads, reads of unmapped offsets and reads of the identification register. A wrong count shows up in the very next 32-bit read. About 70000 ticks take the count past 0xFFFF, so that its upper half is non-zero and a stale or wrongly loaded holding value changes the data that is read back. A mistake in error classification shows up on `err` one cycle after the offending strobe.

// File: rtl/stamp32k_pkg.sv
package stamp32k_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  typedef struct packed {
    logic        refuse;    // access is illegal: error pulse
    logic        take_hold; // return holding register
    logic        load_hold; // capture upper half of word_val
    logic        half;      // return only lower half of word_val
  } acc_kind_t;

endpackage

// File: rtl/stamp32k_counter.sv
module stamp32k_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_en,
  output logic [CNT_W-1:0] count
);

  always_ff @(posedge clk) begin
    if (rst) count <= '0;
    else if (tick_en) count <= count + 1'b1;
  end

  // R1: one step per tick, wrap to zero after all ones
  a_r1_tick_step: assert property (@(posedge clk) disable iff (rst)
    $past(tick_en) && !$past(rst) |-> count == $past(count) + 1'b1);
  a_r1_no_tick_hold: assert property (@(posedge clk) disable iff (rst)
    !$past(tick_en) && !$past(rst) |-> count == $past(count));
  a_r1_wrap: assert property (@(posedge clk) disable iff (rst)
    tick_en && (&count) |=> count == '0);

endmodule

// File: rtl/stamp32k_decode.sv
module stamp32k_decode
  import stamp32k_pkg::*;
#(
  parameter int          ADDR_W  = 8,
  parameter int          DATA_W  = 32,
  parameter logic [ADDR_W-1:0] REV_OFS = 'h00,
  parameter logic [ADDR_W-1:0] CNT_OFS = 'h10,
  parameter logic [DATA_W-1:0] REV_VAL = 'h21
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  input  logic [1:0]        size,
  input  logic [DATA_W-1:0] count,
  output acc_kind_t         kind,
  output logic [DATA_W-1:0] word_val
);

  logic              hit_rev, hit_cnt, hit_none;
  logic [DATA_W-1:0] lookup;

  always_comb begin
    hit_rev  = (addr == REV_OFS);
    hit_cnt  = (addr == CNT_OFS);
    hit_none = !hit_rev && !hit_cnt;
    lookup   = hit_rev ? REV_VAL : (hit_cnt ? count : '0);
  end

  always_comb begin
    kind     = '0;
    word_val = '0;
    if (wr) begin
      kind.refuse = 1'b1;
    end else if (rd) begin
      unique case (acc_size_e'(size))
        SZ_WORD: begin
          word_val    = lookup;
          kind.refuse = hit_none;
        end
        SZ_HALF: begin
          if (addr[1]) begin
            kind.take_hold = 1'b1;
          end else begin
            word_val       = lookup;
            kind.half      = 1'b1;
            kind.load_hold = 1'b1;
            kind.refuse    = hit_none;
          end
        end
        default: kind.refuse = 1'b1;
      endcase
    end
  end

endmodule

// File: rtl/stamp32k_readout.sv
module stamp32k_readout
  import stamp32k_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd,
  input  logic              wr,
  input  logic              hi_addr,
  input  logic [1:0]        size,
  input  acc_kind_t         kind,
  input  logic [DATA_W-1:0] word_val,
  output logic [DATA_W-1:0] rdata,
  output logic              err
);

  localparam int HALF_W = DATA_W / 2;

  logic [HALF_W-1:0] hold_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= '0;
      rdata  <= '0;
      err    <= 1'b0;
    end else begin
      err <= kind.refuse;
      if (kind.take_hold)
        rdata <= {{(DATA_W-HALF_W){1'b0}}, hold_q};
      else if (kind.half)
        rdata <= {{(DATA_W-HALF_W){1'b0}}, word_val[HALF_W-1:0]};
      else
        rdata <= word_val;
      if (kind.load_hold)
        hold_q <= word_val[DATA_W-1:HALF_W];
    end
  end

  // R7: a write leaves the holding register alone and is refused
  a_r7_write_keeps_hold: assert property (@(posedge clk) disable iff (rst)
    wr |=> $stable(hold_q));
  a_r7_write_err: assert property (@(posedge clk) disable iff (rst)
    wr |=> err);
  // R6: upper-half read returns the stored half without error
  a_r6_hold_return: assert property (@(posedge clk) disable iff (rst)
    rd && !wr && size == 2'd1 && hi_addr |=>
      rdata == {{(DATA_W-HALF_W){1'b0}}, $past(hold_q)} && !err);
  // R8: byte and reserved sizes refused, hold untouched
  a_r8_bad_width: assert property (@(posedge clk) disable iff (rst)
    rd && !wr && (size == 2'd0 || size == 2'd3) |=> err && rdata == '0 && $stable(hold_q));
  // R9/R10: refused accesses return zero data
  a_r9_err_zero_data: assert property (@(posedge clk) disable iff (rst)
    err |-> rdata == '0);
  // R10: no strobe, quiet outputs
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !rd && !wr |=> !err && rdata == '0);

endmodule

// File: rtl/stamp32k_timer.sv
module stamp32k_timer
  import stamp32k_pkg::*;
#(
  parameter int          ADDR_W  = 8,
  parameter int          DATA_W  = 32,
  parameter logic [ADDR_W-1:0] REV_OFS = 'h00,
  parameter logic [ADDR_W-1:0] CNT_OFS = 'h10,
  parameter logic [DATA_W-1:0] REV_VAL = 'h21
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [1:0]        bus_size,
  output logic [DATA_W-1:0] rdata,
  output logic              err
);

  logic [DATA_W-1:0] count;
  logic [DATA_W-1:0] word_val;
  acc_kind_t         kind;

  stamp32k_counter #(.CNT_W(DATA_W)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .tick_en (tick_en),
    .count   (count)
  );

  stamp32k_decode #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .REV_OFS(REV_OFS),
    .CNT_OFS(CNT_OFS),
    .REV_VAL(REV_VAL)
  ) u_dec (
    .addr    (bus_addr),
    .rd      (bus_rd),
    .wr      (bus_wr),
    .size    (bus_size),
    .count   (count),
    .kind    (kind),
    .word_val(word_val)
  );

  stamp32k_readout #(.DATA_W(DATA_W)) u_out (
    .clk     (clk),
    .rst     (rst),
    .rd      (bus_rd),
    .wr      (bus_wr),
    .hi_addr (bus_addr[1]),
    .size    (bus_size),
    .kind    (kind),
    .word_val(word_val),
    .rdata   (rdata),
    .err     (err)
  );

  // R3: identification word on a full-width read
  a_r3_rev_word: assert property (@(posedge clk) disable iff (rst)
    bus_rd && !bus_wr && bus_size == 2'd2 && bus_addr == REV_OFS |=> rdata == REV_VAL && !err);
  // R4: full-width count read returns the count at the strobe
  a_r4_count_word: assert property (@(posedge clk) disable iff (rst)
    bus_rd && !bus_wr && bus_size == 2'd2 && bus_addr == CNT_OFS |=> rdata == $past(count) && !err);

endmodule

// File: tb/stamp32k_timer_test.sv
`timescale 1ns/1ps
module stamp32k_timer_test;

  logic        clk = 1'b0;
  logic        rst;
  logic        tick_en;
  logic [7:0]  bus_addr;
  logic        bus_rd;
  logic        bus_wr;
  logic [1:0]  bus_size;
  logic [31:0] rdata;
  logic        err;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [31:0] m_cnt;
  logic [15:0] m_hold;

  always #2 clk = ~clk;

  stamp32k_timer uut (
    .clk(clk), .rst(rst), .tick_en(tick_en), .bus_addr(bus_addr),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_size(bus_size),
    .rdata(rdata), .err(err)
  );

  task automatic step(input logic r, input logic w, input logic [1:0] sz,
                      input logic [7:0] a, input logic t, input string req);
    logic [31:0] word;
    logic        wbad;
    logic [31:0] exp_d;
    logic        exp_e;
    logic [15:0] nh;
    bus_rd = r; bus_wr = w; bus_size = sz; bus_addr = a; tick_en = t;
    if (a == 8'h00) begin word = 32'h21; wbad = 1'b0; end
    else if (a == 8'h10) begin word = m_cnt; wbad = 1'b0; end
    else begin word = 32'h0; wbad = 1'b1; end
    exp_d = 32'h0; exp_e = 1'b0; nh = m_hold;
    if (w) exp_e = 1'b1;
    else if (r) begin
      if (sz == 2'd2) begin
        if (!wbad) exp_d = word;
        exp_e = wbad;
      end else if (sz == 2'd1) begin
        if (a[1]) exp_d = {16'h0, m_hold};
        else begin
          exp_d = {16'h0, word[15:0]};
          exp_e = wbad;
          nh = word[31:16];
        end
      end else exp_e = 1'b1;
    end
    @(posedge clk);
    @(negedge clk);
    checks++;
    if (rdata !== exp_d || err !== exp_e) begin
      errors++;
      $display("FAIL %s: rdata=%h err=%b expected rdata=%h err=%b", req, rdata, err, exp_d, exp_e);
    end
    m_hold = nh;
    if (t) m_cnt = m_cnt + 1;
  endtask

  task automatic idle(input int n, input logic t);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 2'd0, 8'h00, t, "R10 idle/R1");
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; tick_en = 1'b0; bus_rd = 1'b0; bus_wr = 1'b0;
    bus_size = 2'd0; bus_addr = 8'h00;
    m_cnt = 0; m_hold = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    checks++;
    if (rdata !== 32'h0 || err !== 1'b0) begin
      errors++;
      $display("FAIL R2 reset: rdata=%h err=%b expected rdata=0 err=0", rdata, err);
    end
    // R2: counter and hold start at zero
    step(1'b1, 1'b0, 2'd2, 8'h10, 1'b0, "R2 count zero");
    step(1'b1, 1'b0, 2'd1, 8'h12, 1'b0, "R2 hold zero");
    // R1, R4
    idle(5, 1'b1);
    step(1'b1, 1'b0, 2'd2, 8'h10, 1'b1, "R4 count read with tick");
    step(1'b1, 1'b0, 2'd2, 8'h10, 1'b0, "R4/R1 count read after tick");
    idle(3, 1'b0);
    step(1'b1, 1'b0, 2'd2, 8'h10, 1'b0, "R1 no tick no change");
    // R3
    step(1'b1, 1'b0, 2'd2, 8'h00, 1'b0, "R3 revision word");
    // reach upper half nonzero
    for (int i = 0; i < 70000; i++) step(1'b0, 1'b0, 2'd0, 8'h00, 1'b1, "R1 tick run");
    step(1'b1, 1'b0, 2'd2, 8'h10, 1'b0, "R4 large count");
    // R5 and R6 coherency
    step(1'b1, 1'b0, 2'd1, 8'h10, 1'b1, "R5 low half count");
    idle(40, 1'b1);
    step(1'b1, 1'b0, 2'd1, 8'h12, 1'b1, "R6 stored half");
    step(1'b1, 1'b0, 2'd1, 8'h12, 1'b1, "R6 stored half repeat");
    step(1'b1, 1'b0, 2'd1, 8'h06, 1'b0, "R6 any offset bit1");
    // R7 writes change nothing
    step(1'b0, 1'b1, 2'd2, 8'h10, 1'b1, "R7 word write");
    step(1'b0, 1'b1, 2'd1, 8'h10, 1'b0, "R7 half write");
    step(1'b1, 1'b1, 2'd1, 8'h00, 1'b0, "R7 read+write");
    step(1'b1, 1'b0, 2'd1, 8'h12, 1'b0, "R7 hold kept");
    step(1'b1, 1'b0, 2'd2, 8'h10, 1'b0, "R7 count kept");
    // R8
    step(1'b1, 1'b0, 2'd0, 8'h10, 1'b0, "R8 byte read");
    step(1'b1, 1'b0, 2'd3, 8'h00, 1'b0, "R8 reserved size");
    step(1'b1, 1'b0, 2'd1, 8'h12, 1'b0, "R8 hold kept");
    // R9
    step(1'b1, 1'b0, 2'd2, 8'h04, 1'b0, "R9 unmapped word");
    step(1'b1, 1'b0, 2'd2, 8'h11, 1'b0, "R9 unaligned word");
    step(1'b1, 1'b0, 2'd1, 8'h08, 1'b0, "R9/R5 unmapped half clears hold");
    step(1'b1, 1'b0, 2'd1, 8'h12, 1'b0, "R5 hold cleared");
    // R5 revision low half loads zero
    step(1'b1, 1'b0, 2'd1, 8'h10, 1'b0, "R5 reload");
    step(1'b1, 1'b0, 2'd1, 8'h00, 1'b0, "R5 revision low half");
    step(1'b1, 1'b0, 2'd1, 8'h02, 1'b0, "R5 revision upper zero");
    // R10 single-cycle pulse
    step(1'b0, 1'b1, 2'd2, 8'h00, 1'b0, "R10 error strobe");
    idle(2, 1'b0);
    // mixed traffic
    for (int i = 0; i < 4000; i++) begin
      logic [7:0] a;
      int sel;
      sel = $urandom_range(0, 5);
      case (sel)
        0: a = 8'h00;
        1: a = 8'h02;
        2: a = 8'h10;
        3: a = 8'h12;
        4: a = 8'h04;
        default: a = 8'h11;
      endcase
      step(1'($urandom_range(0, 1)), ($urandom_range(0, 7) == 0),
           2'($urandom_range(0, 3)), a, 1'($urandom_range(0, 1)),
           "R4/R5/R6/R7/R8/R9 mixed");
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule